// File: doc/BRIEF.md
# PHY Management Frame Register with Register-File Model

This block gives a host a single 32-bit frame register through which it reads and writes the registers of an attached Ethernet PHY. One register write carries a complete management transaction: the written word holds a start code, an opcode, a PHY address, a register address and a data field. The block checks the frame, performs the access on a modelled PHY, and stores the finished word with its turnaround flag set. A read in the following cycle returns that word. For a read opcode, the data field of the returned word holds the register contents.

Behind the frame register sits a 32-entry, 16-bit PHY register file. The control register clears its reset and restart-negotiation bits by itself when they are written, and a restart updates the status and link-partner registers. A `linkUp` input models the cable state. Every change of `linkUp` updates the link bits and raises a 16-bit management interrupt status that is cleared on read. A writable mask gates that status onto an interrupt output. The host also sees a configuration register with two bits it cannot write.

Top module: `mgmt_frame_phy`

## Requirements
- R1: The host port selects a register with `hostSel`: 0 is the frame word, 1 is configuration, 2 is interrupt status (bits 15:0, upper bits read 0), and 3 is interrupt mask (bits 15:0). `wrEn` writes `wrData` at the clock edge. `rdData` shows the selected register combinationally. After reset the frame word reads 0 and the interrupt status reads 0.
- R2: The frame word fields are start 31:30, opcode 29:28, PHY address 27:23, register address 22:18, turnaround 17:16 and data 15:0. A frame is valid only when start is 01 and the PHY address equals 1.
- R3: Writing an invalid frame touches no PHY register. The stored word is the written word with bit 16 forced to 1.
- R4: A valid frame with opcode 01 stores its data field in the addressed PHY register. Opcodes 00 and 11 touch nothing. Every frame write stores its word with bit 16 set, and that word reads back on the next cycle.
- R5: A valid frame with opcode 10 stores written bits 31:17, then bit 16 = 1, then the addressed PHY register in bits 15:0.
- R6: Writing PHY register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R7: Writing PHY register 0 with bit 9 set stores bit 9 cleared and sets bit 5 of PHY register 1. If `linkUp` is high, it also sets bit 2 of register 1 and bit 8 of register 5.
- R8: Configuration bits 9:8 keep their value on writes; all other bits are writable. The reset value is 0x0000_0100.
- R9: When `linkUp` differs from its value at the previous clock edge, bit 2 of PHY register 1 and bit 8 of register 5 are set equal to `linkUp`, and the interrupt status becomes 0xFFFF. The link is taken as down at reset. This update wins over a clear in the same cycle.
- R10: Reading the interrupt status returns its current value, and the status is cleared to 0 at that clock edge.
- R11: `mgmtIrq` is high exactly when some interrupt-status bit is 1 and its mask bit is 0. The mask resets to 0xFFFF.
- R12: After reset, PHY register 1 reads 0x4028 (bit 14 for 100 Mb/s full duplex, bit 5 for negotiation complete, bit 3 for negotiation ability) and register 4 reads 0x0100. Every other PHY register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (clears status on read) |
| hostSel | input | 2 | Register select |
| wrData | input | 32 | Host write data |
| linkUp | input | 1 | Cable link state |
| rdData | output | 32 | Selected register contents |
| mgmtIrq | output | 1 | Management interrupt |

## Verification
The hardest states to reach are the two restart-negotiation outcomes: complete without link and complete with link. The status and link-partner bits they produce are already set by reset or by a link change. The stimulus therefore first clears PHY registers 1 and 5 with write frames, then writes the restart bit. This is done once with `linkUp` low and once after raising it, and read frames show which bits the restart alone produced. The interrupt path is reached only by toggling `linkUp`. The mask is opened only after the event, so the masked and unmasked states are both observed on `mgmtIrq`.

// File: rtl/mgmt_frame_pkg.sv
package mgmt_frame_pkg;
  localparam int WORD_W = 32;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_CFG   = 2'd1,
    SEL_ISTAT = 2'd2,
    SEL_IMASK = 2'd3
  } hostSel_e;

  localparam logic [1:0] START_OK = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // control register bits
  localparam int CTL_SOFTRST = 15;
  localparam int CTL_ANEN    = 12;
  localparam int CTL_RESTART = 9;
  // status register bits
  localparam int STS_100FD   = 14;
  localparam int STS_ANDONE  = 5;
  localparam int STS_ANABLE  = 3;
  localparam int STS_LINK    = 2;
  // ability bit in advertisement / partner registers
  localparam int ABL_100FD   = 8;

  localparam int REG_CTL  = 0;
  localparam int REG_STS  = 1;
  localparam int REG_ADV  = 4;
  localparam int REG_PART = 5;

  typedef struct packed {
    logic       frameWr;
    logic       phyWr;
    logic       phyRd;
    logic       cfgWr;
    logic       maskWr;
    logic       statClr;
    logic       linkEvt;
    logic [4:0] regAddr;
  } ctrlStrobe_t;
endpackage

// File: rtl/mgmt_frame_ctrl.sv
module mgmt_frame_ctrl
  import mgmt_frame_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  hostSel,
  input  logic [13:0] frameHdr,
  input  logic        linkUp,
  output ctrlStrobe_t strobe
);
  logic linkPrev;
  logic isFrame;
  logic frameOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) linkPrev <= 1'b0;
    else        linkPrev <= linkUp;
  end

  // frameHdr holds wrData[31:18]
  always_comb begin
    isFrame = wrEn && (hostSel == SEL_FRAME);
    frameOk = (frameHdr[13:12] == START_OK) &&
              (frameHdr[9:5] == 5'(PHY_ADDR));
    strobe.frameWr = isFrame;
    strobe.phyWr   = isFrame && frameOk && (frameHdr[11:10] == OP_WRITE);
    strobe.phyRd   = isFrame && frameOk && (frameHdr[11:10] == OP_READ);
    strobe.cfgWr   = wrEn && (hostSel == SEL_CFG);
    strobe.maskWr  = wrEn && (hostSel == SEL_IMASK);
    strobe.statClr = rdEn && (hostSel == SEL_ISTAT);
    strobe.linkEvt = (linkUp != linkPrev);
    strobe.regAddr = frameHdr[4:0];
  end
endmodule

// File: rtl/mgmt_frame_dp.sv
module mgmt_frame_dp
  import mgmt_frame_pkg::*;
#(
  parameter int PHY_REGS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        hostSel,
  input  logic              linkUp,
  output logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] frameWord,
  output logic [WORD_W-1:0] cfgWord,
  output logic [DATA_W-1:0] intStat,
  output logic [DATA_W-1:0] intMask,
  output logic              mgmtIrq
);
  localparam int REG_AW = $clog2(PHY_REGS);
  localparam logic [WORD_W-1:0] TA_DONE  = WORD_W'(32'h0001_0000);
  localparam logic [WORD_W-1:0] CFG_RO   = WORD_W'(32'h0000_0300);
  localparam logic [WORD_W-1:0] CFG_INIT = WORD_W'(32'h0000_0100);

  logic [DATA_W-1:0] phyReg  [PHY_REGS];
  logic [DATA_W-1:0] phyNext [PHY_REGS];
  logic [DATA_W-1:0] ctlData;
  logic [DATA_W-1:0] phyRdVal;
  logic              inRange;
  logic              restart;

  function automatic logic [DATA_W-1:0] initVal(int idx);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx == REG_STS) begin
      v[STS_100FD]  = 1'b1;
      v[STS_ANDONE] = 1'b1;
      v[STS_ANABLE] = 1'b1;
    end
    if (idx == REG_ADV) v[ABL_100FD] = 1'b1;
    return v;
  endfunction

  assign inRange  = int'(strobe.regAddr) < PHY_REGS;
  assign phyRdVal = inRange ? phyReg[strobe.regAddr[REG_AW-1:0]] : '0;

  // control-register write shaping
  always_comb begin
    ctlData = wrData[DATA_W-1:0];
    restart = 1'b0;
    if (ctlData[CTL_SOFTRST]) begin
      ctlData[CTL_SOFTRST] = 1'b0;
      ctlData[CTL_ANEN]    = 1'b1;
    end
    if (ctlData[CTL_RESTART]) begin
      ctlData[CTL_RESTART] = 1'b0;
      restart              = strobe.phyWr && (strobe.regAddr == 5'(REG_CTL));
    end
  end

  always_comb begin
    phyNext = phyReg;
    if (strobe.phyWr && inRange) begin
      if (strobe.regAddr == 5'(REG_CTL)) phyNext[REG_CTL] = ctlData;
      else phyNext[strobe.regAddr[REG_AW-1:0]] = wrData[DATA_W-1:0];
    end
    if (restart) begin
      phyNext[REG_STS][STS_ANDONE] = 1'b1;
      if (linkUp) begin
        phyNext[REG_STS][STS_LINK]   = 1'b1;
        phyNext[REG_PART][ABL_100FD] = 1'b1;
      end
    end
    if (strobe.linkEvt) begin
      phyNext[REG_STS][STS_LINK]   = linkUp;
      phyNext[REG_PART][ABL_100FD] = linkUp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHY_REGS; i++) phyReg[i] <= initVal(i);
    end else begin
      phyReg <= phyNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameWord <= '0;
      cfgWord   <= CFG_INIT;
      intStat   <= '0;
      intMask   <= '1;
    end else begin
      if (strobe.frameWr) begin
        if (strobe.phyRd) frameWord <= {wrData[WORD_W-1:17], 1'b1, phyRdVal};
        else              frameWord <= wrData | TA_DONE;
      end
      if (strobe.cfgWr) cfgWord <= (wrData & ~CFG_RO) | (cfgWord & CFG_RO);
      if (strobe.maskWr) intMask <= wrData[DATA_W-1:0];
      if (strobe.linkEvt)      intStat <= '1;
      else if (strobe.statClr) intStat <= '0;
    end
  end

  always_comb begin
    unique case (hostSel)
      SEL_FRAME: rdData = frameWord;
      SEL_CFG:   rdData = cfgWord;
      SEL_ISTAT: rdData = {{(WORD_W-DATA_W){1'b0}}, intStat};
      default:   rdData = {{(WORD_W-DATA_W){1'b0}}, intMask};
    endcase
  end

  assign mgmtIrq = |(intStat & ~intMask);
endmodule

// File: rtl/mgmt_frame_phy.sv
module mgmt_frame_phy
  import mgmt_frame_pkg::*;
#(
  parameter int PHY_ADDR = 1,
  parameter int PHY_REGS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  hostSel,
  input  logic [31:0] wrData,
  input  logic        linkUp,
  output logic [31:0] rdData,
  output logic        mgmtIrq
);
  ctrlStrobe_t       strobe;
  logic [WORD_W-1:0] frameWord;
  logic [WORD_W-1:0] cfgWord;
  logic [DATA_W-1:0] intStat;
  logic [DATA_W-1:0] intMask;

  mgmt_frame_ctrl #(.PHY_ADDR(PHY_ADDR)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .hostSel  (hostSel),
    .frameHdr (wrData[31:18]),
    .linkUp   (linkUp),
    .strobe   (strobe)
  );

  mgmt_frame_dp #(.PHY_REGS(PHY_REGS)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrData    (wrData),
    .hostSel   (hostSel),
    .linkUp    (linkUp),
    .rdData    (rdData),
    .frameWord (frameWord),
    .cfgWord   (cfgWord),
    .intStat   (intStat),
    .intMask   (intMask),
    .mgmtIrq   (mgmtIrq)
  );
endmodule

// File: rtl/mgmt_frame_phy_chk.sv
module mgmt_frame_phy_chk #(
  parameter int PHY_ADDR = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic        rdEn,
  input logic [1:0]  hostSel,
  input logic [31:0] wrData,
  input logic        linkUp,
  input logic        mgmtIrq,
  input logic [31:0] frameWord,
  input logic [31:0] cfgWord,
  input logic [15:0] intStat,
  input logic [15:0] intMask
);
  logic prevLink;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLink <= 1'b0;
    else        prevLink <= linkUp;
  end

  // R4
  ta_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && hostSel == 2'd0) |=> frameWord[16]);

  // R3
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && hostSel == 2'd0 &&
     (wrData[31:30] != 2'b01 || wrData[27:23] != 5'(PHY_ADDR)))
    |=> frameWord == ($past(wrData) | 32'h0001_0000));

  // R8
  cfg_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && hostSel == 2'd1) |=> cfgWord[9:8] == $past(cfgWord[9:8]));

  // R9
  link_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (linkUp != prevLink) |=> intStat == 16'hFFFF);

  // R10
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && hostSel == 2'd2 && linkUp == prevLink) |=> intStat == 16'h0000);

  // R11
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intMask == 16'hFFFF) |-> !mgmtIrq);

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgmtIrq |-> intStat != 16'h0000);
endmodule

bind mgmt_frame_phy mgmt_frame_phy_chk i_chk (.*);

// File: tb/test_mgmt_frame_phy.sv
module test_mgmt_frame_phy;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [31:0] wrData = '0;
  logic        linkUp = 1'b0;
  logic [31:0] rdData;
  logic        mgmtIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit doneRun = 1'b0;

  always #5 clk = ~clk;

  mgmt_frame_phy i_mgmt_frame_phy (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .hostSel(hostSel),
    .wrData(wrData), .linkUp(linkUp), .rdData(rdData), .mgmtIrq(mgmtIrq)
  );

  // {frame written, frame expected on read-back}
  localparam int NVEC = 17;
  localparam logic [63:0] VEC [NVEC] = '{
    // R12 R5: read status
    {{2'b01,2'b10,5'd1,5'd1,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd1,2'b01,16'h4028}},
    // R12 R5: read advertisement
    {{2'b01,2'b10,5'd1,5'd4,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd4,2'b01,16'h0100}},
    // R4: write reg 7
    {{2'b01,2'b01,5'd1,5'd7,2'b00,16'hA5A5}, {2'b01,2'b01,5'd1,5'd7,2'b01,16'hA5A5}},
    // R5: read reg 7
    {{2'b01,2'b10,5'd1,5'd7,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd7,2'b01,16'hA5A5}},
    // R3: wrong PHY address, data kept
    {{2'b01,2'b10,5'd2,5'd7,2'b00,16'h1234}, {2'b01,2'b10,5'd2,5'd7,2'b01,16'h1234}},
    // R3: wrong start code on a write
    {{2'b00,2'b01,5'd1,5'd7,2'b00,16'h0000}, {2'b00,2'b01,5'd1,5'd7,2'b01,16'h0000}},
    // R3: reg 7 untouched
    {{2'b01,2'b10,5'd1,5'd7,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd7,2'b01,16'hA5A5}},
    // R6: soft reset bit
    {{2'b01,2'b01,5'd1,5'd0,2'b00,16'h8000}, {2'b01,2'b01,5'd1,5'd0,2'b01,16'h8000}},
    {{2'b01,2'b10,5'd1,5'd0,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd0,2'b01,16'h1000}},
    // R7 setup: clear status
    {{2'b01,2'b01,5'd1,5'd1,2'b00,16'h0000}, {2'b01,2'b01,5'd1,5'd1,2'b01,16'h0000}},
    {{2'b01,2'b10,5'd1,5'd1,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd1,2'b01,16'h0000}},
    // R7: restart with link down
    {{2'b01,2'b01,5'd1,5'd0,2'b00,16'h0200}, {2'b01,2'b01,5'd1,5'd0,2'b01,16'h0200}},
    {{2'b01,2'b10,5'd1,5'd0,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd0,2'b01,16'h0000}},
    {{2'b01,2'b10,5'd1,5'd1,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd1,2'b01,16'h0020}},
    {{2'b01,2'b10,5'd1,5'd5,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd5,2'b01,16'h0000}},
    // R4: opcode 11 accesses nothing, turnaround bits in
    {{2'b01,2'b11,5'd1,5'd7,2'b10,16'hFFFF}, {2'b01,2'b11,5'd1,5'd7,2'b11,16'hFFFF}},
    {{2'b01,2'b10,5'd1,5'd7,2'b00,16'h0000}, {2'b01,2'b10,5'd1,5'd7,2'b01,16'hA5A5}}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; hostSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; hostSel = sel;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic phyAccess(input logic [31:0] frame, output logic [31:0] d);
    hostWrite(2'd0, frame);
    hostRead(2'd0, d);
  endtask

  task automatic endRun();
    if (!doneRun) begin
      doneRun = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    endRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    hostRead(2'd0, v); check("R1 frame reset", v, 32'h0);
    hostRead(2'd1, v); check("R8 cfg reset", v, 32'h0000_0100);
    hostRead(2'd2, v); check("R1 status reset", v, 32'h0);
    hostRead(2'd3, v); check("R11 mask reset", v, 32'h0000_FFFF);
    check("R11 irq reset", {31'b0, mgmtIrq}, 32'h0);

    // frame vectors (R2 field layout throughout)
    for (int i = 0; i < NVEC; i++) begin
      phyAccess(VEC[i][63:32], v);
      check($sformatf("R2 frame vector %0d", i), v, VEC[i][31:0]);
    end

    // link up: masked, then unmasked
    @(negedge clk); linkUp = 1'b1;
    @(negedge clk);
    check("R11 irq masked", {31'b0, mgmtIrq}, 32'h0);
    hostWrite(2'd3, 32'h0);
    check("R11 irq unmasked", {31'b0, mgmtIrq}, 32'h1);
    hostRead(2'd2, v); check("R9 status after link up", v, 32'h0000_FFFF);
    hostRead(2'd2, v); check("R10 status cleared", v, 32'h0);
    check("R10 irq after clear", {31'b0, mgmtIrq}, 32'h0);
    phyAccess({2'b01,2'b10,5'd1,5'd1,2'b00,16'h0}, v);
    check("R9 link bit set", v, {2'b01,2'b10,5'd1,5'd1,2'b01,16'h0024});
    phyAccess({2'b01,2'b10,5'd1,5'd5,2'b00,16'h0}, v);
    check("R9 partner bit set", v, {2'b01,2'b10,5'd1,5'd5,2'b01,16'h0100});

    // restart with link up
    phyAccess({2'b01,2'b01,5'd1,5'd1,2'b00,16'h0}, v);
    phyAccess({2'b01,2'b01,5'd1,5'd5,2'b00,16'h0}, v);
    phyAccess({2'b01,2'b01,5'd1,5'd0,2'b00,16'h0200}, v);
    phyAccess({2'b01,2'b10,5'd1,5'd1,2'b00,16'h0}, v);
    check("R7 status with link", v, {2'b01,2'b10,5'd1,5'd1,2'b01,16'h0024});
    phyAccess({2'b01,2'b10,5'd1,5'd5,2'b00,16'h0}, v);
    check("R7 partner with link", v, {2'b01,2'b10,5'd1,5'd5,2'b01,16'h0100});

    // configuration read-only bits
    hostWrite(2'd1, 32'hFFFF_FFFF);
    hostRead(2'd1, v); check("R8 cfg all ones", v, 32'hFFFF_FDFF);
    hostWrite(2'd1, 32'h0);
    hostRead(2'd1, v); check("R8 cfg zero", v, 32'h0000_0100);

    // link down
    @(negedge clk); linkUp = 1'b0;
    @(negedge clk);
    check("R11 irq on link down", {31'b0, mgmtIrq}, 32'h1);
    phyAccess({2'b01,2'b10,5'd1,5'd1,2'b00,16'h0}, v);
    check("R9 link bit cleared", v, {2'b01,2'b10,5'd1,5'd1,2'b01,16'h0020});
    hostRead(2'd2, v); check("R9 status after link down", v, 32'h0000_FFFF);

    endRun();
  end
endmodule